// File: doc/BRIEF.md
# PCI Parity and Error Reporter

This block sits beside the bus interface of a host bridge that acts both as target and as master. It computes the parity bit the bridge must drive for the address or data it places on the bus. It checks the parity of address and data it receives from other agents. On a data parity error it drives the active-low parity error line, and it collects every system-level error source into one active-low system error line.

Each system error source carries its own enable condition. All of them sit under one global system error enable. Every source records a sticky status bit. Software clears these bits by writing ones to a clear input.

Two system error pulses are always separated by at least one idle clock. Sources that arrive in the same clock share one pulse. Sources that arrive while a pulse is on the bus are held back and produce one more pulse after it.

All configuration enables arrive as plain inputs. Command decoding and bus sequencing are left to the surrounding bridge logic, which supplies the phase qualifiers.

Top module: `pci_err_unit`

## Requirements
- R1: When `drive_par_i` is high in a clock, `par_o` in the next clock equals the XOR of the 32 `ad_i` bits and the 4 `cbe_ni` bits of that clock. This makes the 37 bits an even-parity group. `par_oe_o` is high in exactly the clocks that follow a clock with `drive_par_i` high.
- R2: A clock with `rx_data_i` high latches AD and C/BE#. In the next clock `par_i` is compared against the latched bits. On a mismatch, `perr_no` is low and `perr_oe_o` is high for exactly one clock, namely the clock after the one in which `par_i` was sampled.
- R3: `perr_no` is never driven low unless `par_resp_en_i` was high in the clock the mismatch was sampled.
- R4: `serr_no` is never low unless `serr_en_i` was high in the preceding clock.
- R5: `mst_tabort_i` high in a clock makes `serr_no` low for exactly one clock, the next one, when `serr_en_i` is high and no pulse is in progress.
- R6: An address parity mismatch (a clock with `addr_phase_i` high, followed by a wrong `par_i`) pulses `serr_no` only when `par_resp_en_i`, `serr_en_i` and `apar_serr_en_i` are all high.
- R7: `ecc_ce_i` pulses `serr_no` when `ecc_mode_i`, `ecc_ce_serr_en_i` and `serr_en_i` are high. `ecc_ue_i` does the same with `ecc_ue_serr_en_i` in place of `ecc_ce_serr_en_i`.
- R8: `perr_ni` sampled low pulses `serr_no` when `perr_serr_en_i` and `serr_en_i` are high.
- R9: `ext_serr_i` sampled high pulses `serr_no` when `ext_serr_en_i` and `serr_en_i` are high.
- R10: Sources that arrive in the same clock produce a single one-clock pulse. A source that arrives while `serr_no` is low produces one more pulse, starting two clocks later, after one idle clock.
- R11: `status_o` bit positions are: 0 address parity, 1 target abort, 2 correctable ECC, 3 uncorrectable ECC, 4 sampled PERR#, 5 external. A bit is set in the clock after its source occurs with its own enable condition met, whatever the state of `serr_en_i`. It stays set until a one on the matching `status_clr_i` bit. A new event in the same clock as the clear wins.
- R12: After reset, `par_oe_o`, `perr_oe_o` and `serr_oe_o` are low, `perr_no` and `serr_no` are high, and `status_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Sampled address/data bus |
| cbe_ni | input | 4 | Sampled command/byte enables (bus polarity) |
| par_i | input | 1 | Sampled parity line |
| perr_ni | input | 1 | Sampled parity error line |
| addr_phase_i | input | 1 | Address phase received this clock |
| rx_data_i | input | 1 | Data received by the bridge this clock |
| drive_par_i | input | 1 | Bridge drives AD this clock |
| ecc_ce_i | input | 1 | Correctable ECC error pulse |
| ecc_ue_i | input | 1 | Uncorrectable ECC error pulse |
| mst_tabort_i | input | 1 | Target abort on a bridge-initiated transaction |
| ext_serr_i | input | 1 | External system error request |
| par_resp_en_i | input | 1 | Parity error response enable |
| serr_en_i | input | 1 | Global system error enable |
| apar_serr_en_i | input | 1 | Address parity to system error enable |
| ecc_mode_i | input | 1 | ECC operation on |
| ecc_ce_serr_en_i | input | 1 | Correctable ECC to system error enable |
| ecc_ue_serr_en_i | input | 1 | Uncorrectable ECC to system error enable |
| perr_serr_en_i | input | 1 | Sampled PERR# to system error enable |
| ext_serr_en_i | input | 1 | External request to system error enable |
| status_clr_i | input | 6 | Write-one-to-clear for status bits |
| par_o | output | 1 | Parity value to drive |
| par_oe_o | output | 1 | Parity output enable |
| perr_no | output | 1 | Parity error pulse, active low |
| perr_oe_o | output | 1 | Parity error output enable |
| serr_no | output | 1 | System error pulse, active low |
| serr_oe_o | output | 1 | System error output enable |
| status_o | output | 6 | Sticky error status |

## Verification
The parity error pulse and the system error pulse can fall in the same clock. The bench provokes this by sending a bad data parity bit in the same clock as a master target abort, and it expects both lines low in the following clock. The aggregator can also meet a new source while its own pulse is on the bus. The bench raises a second source during an active pulse and expects high, low, high over the next three clocks. A source raised in the same clock as its status clear is judged by the status bit staying set.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;
  localparam int NSRC       = 6;
  localparam int SRC_APAR   = 0;
  localparam int SRC_TABORT = 1;
  localparam int SRC_ECC_CE = 2;
  localparam int SRC_ECC_UE = 3;
  localparam int SRC_PERR   = 4;
  localparam int SRC_EXT    = 5;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/pci_par_unit.sv
module pci_par_unit #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_ni,
  input  logic             par_i,
  input  logic             addr_phase_i,
  input  logic             rx_data_i,
  input  logic             drive_par_i,
  input  logic             par_resp_en_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_no,
  output logic             perr_oe_o,
  output logic             apar_err_o
);
  localparam int GRP_W = AD_W + CBE_W;

  logic [GRP_W-1:0] grp_q;
  logic             chk_addr_q, chk_data_q;
  logic             par_q, par_oe_q, perr_q;
  logic             bad_par;

  // group parity plus sampled PAR must be even
  assign bad_par = ^{grp_q, par_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q      <= '0;
      chk_addr_q <= 1'b0;
      chk_data_q <= 1'b0;
      par_q      <= 1'b0;
      par_oe_q   <= 1'b0;
      perr_q     <= 1'b0;
    end else begin
      grp_q      <= {ad_i, cbe_ni};
      chk_addr_q <= addr_phase_i;
      chk_data_q <= rx_data_i;
      par_q      <= ^{ad_i, cbe_ni};
      par_oe_q   <= drive_par_i;
      perr_q     <= chk_data_q & par_resp_en_i & bad_par;
    end
  end

  assign apar_err_o = chk_addr_q & bad_par;
  assign par_o      = par_q;
  assign par_oe_o   = par_oe_q;
  assign perr_no    = ~perr_q;
  assign perr_oe_o  = perr_q;

  p_par_oe_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_oe_o |-> $past(drive_par_i));
  p_perr_after_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> $past(chk_data_q));
  p_perr_one_clk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!perr_no && !rx_data_i) |=> perr_no);
  p_perr_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> $past(par_resp_en_i));
endmodule

// File: rtl/pci_serr_agg.sv
module pci_serr_agg
  import pci_err_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  src_vec_t loc_en_i,
  input  logic     serr_en_i,
  input  src_vec_t status_clr_i,
  output logic     serr_no,
  output logic     serr_oe_o,
  output src_vec_t status_o
);
  src_vec_t qual;
  src_vec_t status_q;
  logic     any_req, serr_q, pend_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign qual[i] = evt_i[i] & loc_en_i[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[i] <= 1'b0;
      else         status_q[i] <= qual[i] | (status_q[i] & ~status_clr_i[i]);
    end
    p_status_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_q[i]) |-> $past(status_clr_i[i]));
  end

  assign any_req = serr_en_i & (|qual);

  // one pending bit: arrivals during a pulse merge into one follow-up pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serr_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      serr_q <= serr_en_i & ~serr_q & (any_req | pend_q);
      pend_q <= serr_en_i & serr_q & (pend_q | any_req);
    end
  end

  assign serr_no   = ~serr_q;
  assign serr_oe_o = serr_q;
  assign status_o  = status_q;

  p_serr_global_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> $past(serr_en_i));
  p_serr_one_clk_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |=> serr_no);
  p_tabort_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[SRC_TABORT] && serr_en_i && serr_no) |=> !serr_no);
endmodule

// File: rtl/pci_err_unit.sv
module pci_err_unit
  import pci_err_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_ni,
  input  logic             par_i,
  input  logic             perr_ni,
  input  logic             addr_phase_i,
  input  logic             rx_data_i,
  input  logic             drive_par_i,
  input  logic             ecc_ce_i,
  input  logic             ecc_ue_i,
  input  logic             mst_tabort_i,
  input  logic             ext_serr_i,
  input  logic             par_resp_en_i,
  input  logic             serr_en_i,
  input  logic             apar_serr_en_i,
  input  logic             ecc_mode_i,
  input  logic             ecc_ce_serr_en_i,
  input  logic             ecc_ue_serr_en_i,
  input  logic             perr_serr_en_i,
  input  logic             ext_serr_en_i,
  input  logic [NSRC-1:0]  status_clr_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_no,
  output logic             perr_oe_o,
  output logic             serr_no,
  output logic             serr_oe_o,
  output logic [NSRC-1:0]  status_o
);
  logic     apar_err;
  src_vec_t evt, loc_en;

  pci_par_unit #(.AD_W(AD_W), .CBE_W(CBE_W)) u_par (
    .clk_i, .rst_ni, .ad_i, .cbe_ni, .par_i, .addr_phase_i, .rx_data_i,
    .drive_par_i, .par_resp_en_i, .par_o, .par_oe_o, .perr_no, .perr_oe_o,
    .apar_err_o(apar_err)
  );

  always_comb begin
    evt                = '0;
    evt[SRC_APAR]      = apar_err;
    evt[SRC_TABORT]    = mst_tabort_i;
    evt[SRC_ECC_CE]    = ecc_ce_i;
    evt[SRC_ECC_UE]    = ecc_ue_i;
    evt[SRC_PERR]      = ~perr_ni;
    evt[SRC_EXT]       = ext_serr_i;
    loc_en             = '0;
    loc_en[SRC_APAR]   = par_resp_en_i & apar_serr_en_i;
    loc_en[SRC_TABORT] = 1'b1;
    loc_en[SRC_ECC_CE] = ecc_mode_i & ecc_ce_serr_en_i;
    loc_en[SRC_ECC_UE] = ecc_mode_i & ecc_ue_serr_en_i;
    loc_en[SRC_PERR]   = perr_serr_en_i;
    loc_en[SRC_EXT]    = ext_serr_en_i;
  end

  pci_serr_agg u_agg (
    .clk_i, .rst_ni, .evt_i(evt), .loc_en_i(loc_en), .serr_en_i,
    .status_clr_i, .serr_no, .serr_oe_o, .status_o
  );
endmodule

// File: tb/pci_err_unit_tb_top.sv
module pci_err_unit_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic par = 1'b0, perr_n = 1'b1, addr_ph = 1'b0, rx_data = 1'b0, drv_par = 1'b0;
  logic ecc_ce = 1'b0, ecc_ue = 1'b0, tabort = 1'b0, ext = 1'b0;
  logic par_resp = 1'b0, serr_en = 1'b0, apar_en = 1'b0, ecc_mode = 1'b0;
  logic ce_en = 1'b0, ue_en = 1'b0, perr_en = 1'b0, ext_en = 1'b0;
  logic [5:0] clr = '0;
  logic par_o, par_oe, perr_no, perr_oe, serr_no, serr_oe;
  logic [5:0] status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pci_err_unit dut_i (
    .clk_i(clk), .rst_ni, .ad_i(ad), .cbe_ni(cbe), .par_i(par), .perr_ni(perr_n),
    .addr_phase_i(addr_ph), .rx_data_i(rx_data), .drive_par_i(drv_par),
    .ecc_ce_i(ecc_ce), .ecc_ue_i(ecc_ue), .mst_tabort_i(tabort), .ext_serr_i(ext),
    .par_resp_en_i(par_resp), .serr_en_i(serr_en), .apar_serr_en_i(apar_en),
    .ecc_mode_i(ecc_mode), .ecc_ce_serr_en_i(ce_en), .ecc_ue_serr_en_i(ue_en),
    .perr_serr_en_i(perr_en), .ext_serr_en_i(ext_en), .status_clr_i(clr),
    .par_o, .par_oe_o(par_oe), .perr_no, .perr_oe_o(perr_oe), .serr_no,
    .serr_oe_o(serr_oe), .status_o(status)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic gpar(input logic [31:0] a, input logic [3:0] c);
    return 1'(($countones(a) + $countones(c)) % 2);
  endfunction

  task automatic cfg_off();
    par_resp = 0; serr_en = 0; apar_en = 0; ecc_mode = 0;
    ce_en = 0; ue_en = 0; perr_en = 0; ext_en = 0;
  endtask

  task automatic clear_status();
    clr = 6'h3f; tick(); clr = '0;
    chk("R11 clear", 32'(status), 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic exp_par;
    logic glob, loc;
    #20;
    chk("R12 par_oe", 32'(par_oe), 0);
    chk("R12 perr_no", 32'(perr_no), 1);
    chk("R12 perr_oe", 32'(perr_oe), 0);
    chk("R12 serr_no", 32'(serr_no), 1);
    chk("R12 serr_oe", 32'(serr_oe), 0);
    chk("R12 status", 32'(status), 0);
    rst_ni = 1'b1;
    tick();

    // R1 parity generation sweep
    for (int i = 0; i < 200; i++) begin
      ad = (i * 32'h9E3779B9) ^ (32'(i) << 7);
      cbe = 4'(i);
      drv_par = (i % 5) != 4;
      tick();
      if (drv_par) chk("R1 par_o", 32'(par_o), 32'(gpar(ad, cbe)));
      chk("R1 par_oe", 32'(par_oe), 32'(drv_par));
    end
    drv_par = 0;

    // R2/R3 data parity check sweep
    for (int i = 0; i < 64; i++) begin
      ad = 32'hA5A5_0000 ^ (i * 32'h0101_0307);
      cbe = 4'(i >> 2);
      par_resp = i[1];
      rx_data = 1; tick();
      rx_data = 0; exp_par = gpar(ad, cbe);
      par = exp_par ^ i[0];
      ad = ~ad;
      tick();
      chk("R2 R3 perr_no", 32'(perr_no), 32'(!(i[0] & i[1])));
      chk("R2 perr_oe", 32'(perr_oe), 32'(i[0] & i[1]));
      par = 0; tick();
      chk("R2 perr one clock", 32'(perr_no), 1);
    end
    par_resp = 0;
    chk("R2 no serr from data parity", 32'(serr_no), 1);

    // R4..R9, R11 per-source sweep
    for (int s = 0; s < 6; s++) begin
      for (int e = 0; e < 8; e++) begin
        cfg_off();
        glob = e[0];
        serr_en = glob;
        case (s)
          0: begin par_resp = e[1]; apar_en = e[2]; loc = e[1] & e[2]; end
          1: loc = 1;
          2: begin ecc_mode = e[1]; ce_en = e[2]; loc = e[1] & e[2]; end
          3: begin ecc_mode = e[1]; ue_en = e[2]; loc = e[1] & e[2]; end
          4: begin perr_en = e[1]; loc = e[1]; end
          default: begin ext_en = e[1]; loc = e[1]; end
        endcase
        if (s == 0) begin
          ad = 32'h1234_5678 + 32'(e); cbe = 4'(e);
          addr_ph = 1; tick();
          addr_ph = 0; par = ~gpar(ad, cbe);
        end else begin
          case (s)
            1: tabort = 1;
            2: ecc_ce = 1;
            3: ecc_ue = 1;
            4: perr_n = 0;
            default: ext = 1;
          endcase
        end
        tick();
        par = 0; tabort = 0; ecc_ce = 0; ecc_ue = 0; perr_n = 1; ext = 0;
        case (s)
          0: chk("R6 R4 addr parity serr", 32'(serr_no), 32'(!(glob & loc)));
          1: chk("R5 R4 tabort serr", 32'(serr_no), 32'(!(glob & loc)));
          2: chk("R7 R4 ecc ce serr", 32'(serr_no), 32'(!(glob & loc)));
          3: chk("R7 R4 ecc ue serr", 32'(serr_no), 32'(!(glob & loc)));
          4: chk("R8 R4 perr sampled serr", 32'(serr_no), 32'(!(glob & loc)));
          default: chk("R9 R4 ext serr", 32'(serr_no), 32'(!(glob & loc)));
        endcase
        chk("R11 status set", 32'(status), 32'(loc) << s);
        chk("R2 perr quiet", 32'(perr_no), 1);
        tick();
        chk("R5 R10 single clock pulse", 32'(serr_no), 1);
        chk("R11 status sticky", 32'(status), 32'(loc) << s);
        clear_status();
      end
    end

    // R10 pending and merging
    cfg_off(); serr_en = 1; ext_en = 1;
    tabort = 1; tick();
    chk("R10 first pulse", 32'(serr_no), 0);
    tabort = 0; ext = 1; tick();
    chk("R10 idle while pending", 32'(serr_no), 1);
    ext = 0; tick();
    chk("R10 pending pulse", 32'(serr_no), 0);
    tick(); chk("R10 after pending", 32'(serr_no), 1);
    tick(); chk("R10 no extra", 32'(serr_no), 1);
    tabort = 1; ext = 1; tick();
    chk("R10 merged pulse", 32'(serr_no), 0);
    tabort = 0; ext = 0; tick();
    chk("R10 merged ends", 32'(serr_no), 1);
    tick(); chk("R10 merged single", 32'(serr_no), 1);
    clear_status();

    // PERR and SERR in the same clock
    par_resp = 1; ad = 32'hDEAD_BEEF; cbe = 4'h6;
    rx_data = 1; tick();
    rx_data = 0; par = ~gpar(ad, cbe); tabort = 1; tick();
    chk("R2 perr with serr", 32'(perr_no), 0);
    chk("R5 serr with perr", 32'(serr_no), 0);
    par = 0; tabort = 0; tick();
    chk("R2 perr released", 32'(perr_no), 1);
    chk("R5 serr released", 32'(serr_no), 1);
    clear_status();

    // R11 set wins over clear
    ext = 1; clr = 6'h20; tick();
    ext = 0; clr = '0;
    chk("R11 set wins", 32'(status), 32'h20);
    tick();
    clear_status();

    // R4 global disable with all local enables on
    cfg_off(); ext_en = 1; perr_en = 1;
    ext = 1; perr_n = 0; tabort = 1; tick();
    ext = 0; perr_n = 1; tabort = 0;
    chk("R4 no serr when disabled", 32'(serr_no), 1);
    chk("R11 status without global", 32'(status), 32'h32);
    tick();
    chk("R4 still quiet", 32'(serr_no), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule